// File: doc/BRIEF.md
# Full-Map Coherence Directory Controller

This block keeps the coherence state of every shareable, cacheable memory line for a fixed number of processor caches. Each line's entry holds one presence flag per cache and a single dirty flag. Caches never watch one another's traffic. Instead they send the directory a plain read or a read-for-ownership tagged with their cache number. From the stored entry the directory works out which caches are involved. It sends a targeted invalidate to the current sharers, or a write-back request to the cache holding a modified copy, and answers the requester with a grant once those caches have responded.

One transaction is handled at a time. While a write-back or a round of invalidations is outstanding, the request port is held not-ready, so a second request, to any line, waits at the port. The number of caches and the number of tracked lines are build-time parameters. The presence vector is exactly one bit per cache.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every line is empty (no presence flag set, clean), `req_ready` is high, and `grant_valid`, `inv_valid` and `wb_valid` are low.
- R2: A read of a clean line sets the requester's presence flag and raises `grant_valid` in the cycle after the request is accepted, with no invalidate or write-back. Reads from several caches accumulate presence flags, and the line stays clean.
- R3: A read-for-ownership of a clean line that other caches hold raises `inv_valid` for exactly one cycle, in the cycle after acceptance. `inv_mask` has bit i set for each cache i holding the line except the requester, and `msg_line` gives the line.
- R4: After an invalidate, the grant is raised in the cycle after the last required `inv_ack` bit is sampled. `inv_ack` bits of caches outside the mask have no effect. Afterwards only the requester holds the line, and the line is dirty.
- R5: A read-for-ownership of a line that no other cache holds is granted in the cycle after acceptance without any message, and it leaves the requester as the sole, dirty holder.
- R6: A read of a dirty line owned by another cache raises `wb_valid` for one cycle with `wb_owner` set to the owner's number. The grant follows in the cycle after `wb_done` is sampled. The line is then clean and held by both the former owner and the requester.
- R7: A read-for-ownership of a dirty line owned by another cache first requests a write-back from the owner. In the cycle after `wb_done` it sends an invalidate whose mask holds only the former owner. It grants after that acknowledgement, and the requester becomes the sole, dirty holder.
- R8: A read or read-for-ownership from the cache that already owns a dirty line is granted in the cycle after acceptance with no message, and the entry is unchanged.
- R9: While a write-back or invalidate round is outstanding, `req_ready` is low and no request is accepted, whatever its line.
- R10: A grant carries the requester's number on `grant_id`, the line on `grant_line`, and `grant_excl` = 1 for read-for-ownership, 0 for a read.
- R11: Entries of different lines are independent: a transaction on one line leaves every other line's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Directory can accept a request this cycle |
| req_rwitm | input | 1 | 1 = read-for-ownership, 0 = plain read |
| req_id | input | IDW | Requesting cache number |
| req_line | input | LW | Line index of the request |
| inv_valid | output | 1 | One-cycle invalidate message |
| inv_mask | output | N_CACHE | Caches that must invalidate (bit i = cache i) |
| inv_ack | input | N_CACHE | Invalidate acknowledgement pulses, bit per cache |
| wb_valid | output | 1 | One-cycle write-back request |
| wb_owner | output | IDW | Cache that must write its modified copy back |
| wb_done | input | 1 | Write-back to memory complete |
| msg_line | output | LW | Line named by the current invalidate or write-back |
| grant_valid | output | 1 | One-cycle grant |
| grant_id | output | IDW | Cache being granted |
| grant_line | output | LW | Line being granted |
| grant_excl | output | 1 | Grant is for ownership |

## Verification
The hardest situation to reach is a read-for-ownership against a line that another cache holds dirty. It chains a write-back, an invalidate of the former owner and a grant, and a second request to an unrelated line arrives in the middle. The bench first makes one cache the dirty owner of a line. It then forks a read-for-ownership from a second cache with a delayed read to another line, and the responders stretch the write-back and acknowledgements so that the stall lasts several cycles. The acknowledgement responder also raises bits outside the invalidate mask on every pulse, so unrequested acknowledgements are present on every round.

// File: rtl/coh_dir_pkg.sv
// Package: shared types for the coherence directory controller.
// Assumes: nothing beyond IEEE 1800-2017.
package coh_dir_pkg;

    // Sequencer phase: idle, awaiting a write-back, awaiting invalidate acks.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WB   = 2'd1,
        PH_INV  = 2'd2
    } dir_phase_e;

endpackage

// File: rtl/coh_dir_store.sv
// Module: directory entry storage, one presence vector and one dirty flag per line.
// One combinational read port and one synchronous write port.
// Assumes: LINES is a power of two; the writer keeps a dirty line to a single holder.
module coh_dir_store #(
    parameter int N_CACHE = 4,
    parameter int LINES   = 16,
    localparam int LW     = $clog2(LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LW-1:0]      rd_line,
    output logic [N_CACHE-1:0] rd_pres,
    output logic               rd_dirty,
    input  logic               wr_en,
    input  logic [LW-1:0]      wr_line,
    input  logic [N_CACHE-1:0] wr_pres,
    input  logic               wr_dirty
);

    logic [N_CACHE-1:0] pres_q  [LINES];
    logic               dirty_q [LINES];

    // Entry update: clear all on reset, otherwise write one line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                pres_q[i]  <= '0;
                dirty_q[i] <= 1'b0;
            end
        end else if (wr_en) begin
            pres_q[wr_line]  <= wr_pres;
            dirty_q[wr_line] <= wr_dirty;
        end
    end

    // Lookup of the addressed entry.
    always_comb begin
        rd_pres  = pres_q[rd_line];
        rd_dirty = dirty_q[rd_line];
    end

    // A dirty line always has exactly one holder (R4, R5, R7).
    for (genvar g = 0; g < LINES; g++) begin : g_chk
        a_r4_dirty_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
            dirty_q[g] |-> ($countones(pres_q[g]) == 1));
    end

endmodule

// File: rtl/coh_dir_ack_track.sv
// Module: outstanding-invalidate tracker.
// Loads the set of caches sent an invalidate and clears bits as acks arrive;
// acks for caches not in the set are dropped.
// Assumes: a new load only happens when nothing is outstanding.
module coh_dir_ack_track #(
    parameter int N_CACHE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [N_CACHE-1:0] load_mask,
    input  logic [N_CACHE-1:0] ack,
    output logic               last_ack
);

    logic [N_CACHE-1:0] pend_q;

    // Pending set: load on issue, shrink on each acknowledgement.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend_q <= '0;
        else if (load) pend_q <= load_mask;
        else           pend_q <= pend_q & ~ack;
    end

    // The remaining pending caches all acknowledge this cycle.
    always_comb last_ack = (pend_q != '0) && ((pend_q & ~ack) == '0);

    // No new invalidate round while one is still open (R9).
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (pend_q == '0));

    // Acks outside the pending set never add bits (R4).
    a_r4_only_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((pend_q & ~$past(pend_q)) == '0));

endmodule

// File: rtl/coh_dir_ctrl.sv
// Module: full-map coherence directory controller (top).
// Accepts read / read-for-ownership requests, issues targeted invalidates or a
// write-back request to the dirty owner, and grants once the caches answer.
// Assumes: one transaction at a time; N_CACHE >= 2; LINES a power of two;
// each cache acks each invalidate once and wb_done follows each wb_valid.
module coh_dir_ctrl
    import coh_dir_pkg::*;
#(
    parameter int N_CACHE = 4,
    parameter int LINES   = 16,
    localparam int IDW    = $clog2(N_CACHE),
    localparam int LW     = $clog2(LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_rwitm,
    input  logic [IDW-1:0]     req_id,
    input  logic [LW-1:0]      req_line,
    output logic               inv_valid,
    output logic [N_CACHE-1:0] inv_mask,
    input  logic [N_CACHE-1:0] inv_ack,
    output logic               wb_valid,
    output logic [IDW-1:0]     wb_owner,
    input  logic               wb_done,
    output logic [LW-1:0]      msg_line,
    output logic               grant_valid,
    output logic [IDW-1:0]     grant_id,
    output logic [LW-1:0]      grant_line,
    output logic               grant_excl
);

    localparam logic [N_CACHE-1:0] ONE = {{(N_CACHE-1){1'b0}}, 1'b1};

    dir_phase_e         phase_q, phase_d;
    logic [IDW-1:0]     cur_id_q;
    logic [LW-1:0]      cur_line_q;
    logic               cur_excl_q;

    logic [IDW-1:0]     sel_id;
    logic [LW-1:0]      sel_line;
    logic               sel_excl;
    logic [N_CACHE-1:0] sel_bit, rd_pres, others;
    logic               rd_dirty;

    logic               wr_en, wr_dirty;
    logic [N_CACHE-1:0] wr_pres;
    logic               do_grant, do_inv, do_wb, accept, last_ack;
    logic [N_CACHE-1:0] inv_set;

    // Lowest-numbered holder in a presence vector.
    function automatic logic [IDW-1:0] first_holder(input logic [N_CACHE-1:0] v);
        first_holder = '0;
        for (int i = N_CACHE - 1; i >= 0; i--)
            if (v[i]) first_holder = IDW'(i);
    endfunction

    coh_dir_store #(.N_CACHE(N_CACHE), .LINES(LINES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_line  (sel_line),
        .rd_pres  (rd_pres),
        .rd_dirty (rd_dirty),
        .wr_en    (wr_en),
        .wr_line  (sel_line),
        .wr_pres  (wr_pres),
        .wr_dirty (wr_dirty)
    );

    coh_dir_ack_track #(.N_CACHE(N_CACHE)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_inv),
        .load_mask (inv_set),
        .ack       (inv_ack),
        .last_ack  (last_ack)
    );

    // Request source: port while idle, captured request otherwise.
    always_comb begin
        req_ready = (phase_q == PH_IDLE);
        accept    = req_ready && req_valid;
        sel_id    = req_ready ? req_id    : cur_id_q;
        sel_line  = req_ready ? req_line  : cur_line_q;
        sel_excl  = req_ready ? req_rwitm : cur_excl_q;
        sel_bit   = ONE << sel_id;
        others    = rd_pres & ~sel_bit;
    end

    // Decision logic: next phase, entry update and messages to issue.
    always_comb begin
        phase_d  = phase_q;
        wr_en    = 1'b0;
        wr_pres  = rd_pres;
        wr_dirty = rd_dirty;
        do_grant = 1'b0;
        do_inv   = 1'b0;
        do_wb    = 1'b0;
        inv_set  = others;
        unique case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    if (rd_dirty && rd_pres[sel_id]) begin
                        do_grant = 1'b1;
                    end else if (rd_dirty) begin
                        do_wb   = 1'b1;
                        phase_d = PH_WB;
                    end else if (!sel_excl) begin
                        wr_en    = 1'b1;
                        wr_pres  = rd_pres | sel_bit;
                        wr_dirty = 1'b0;
                        do_grant = 1'b1;
                    end else if (others != '0) begin
                        do_inv  = 1'b1;
                        phase_d = PH_INV;
                    end else begin
                        wr_en    = 1'b1;
                        wr_pres  = sel_bit;
                        wr_dirty = 1'b1;
                        do_grant = 1'b1;
                    end
                end
            end
            PH_WB: begin
                if (wb_done) begin
                    if (!sel_excl) begin
                        wr_en    = 1'b1;
                        wr_pres  = rd_pres | sel_bit;
                        wr_dirty = 1'b0;
                        do_grant = 1'b1;
                        phase_d  = PH_IDLE;
                    end else begin
                        do_inv  = 1'b1;
                        phase_d = PH_INV;
                    end
                end
            end
            PH_INV: begin
                if (last_ack) begin
                    wr_en    = 1'b1;
                    wr_pres  = sel_bit;
                    wr_dirty = 1'b1;
                    do_grant = 1'b1;
                    phase_d  = PH_IDLE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Sequencer state and captured request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            cur_id_q   <= '0;
            cur_line_q <= '0;
            cur_excl_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (accept) begin
                cur_id_q   <= req_id;
                cur_line_q <= req_line;
                cur_excl_q <= req_rwitm;
            end
        end
    end

    // Registered message and grant outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_valid   <= 1'b0;
            inv_mask    <= '0;
            wb_valid    <= 1'b0;
            wb_owner    <= '0;
            msg_line    <= '0;
            grant_valid <= 1'b0;
            grant_id    <= '0;
            grant_line  <= '0;
            grant_excl  <= 1'b0;
        end else begin
            inv_valid   <= do_inv;
            wb_valid    <= do_wb;
            grant_valid <= do_grant;
            if (do_inv) inv_mask <= inv_set;
            if (do_wb)  wb_owner <= first_holder(rd_pres);
            if (do_inv || do_wb) msg_line <= sel_line;
            if (do_grant) begin
                grant_id   <= sel_id;
                grant_line <= sel_line;
                grant_excl <= sel_excl;
            end
        end
    end

    // Invalidates never target the requester and never go out empty (R3).
    a_r3_inv_targets_others: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (!inv_mask[cur_id_q] && (inv_mask != '0)));

    // Write-back is requested from a cache other than the requester (R6).
    a_r6_wb_not_requester: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_owner != cur_id_q));

    // Leaving idle always coincides with a message going out (R9).
    a_r9_busy_has_message: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> (inv_valid || wb_valid));

    // Messages are single-cycle pulses (R3, R6).
    a_r3_inv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> !inv_valid);

    // A grant never coincides with an outstanding message (R10).
    a_r10_grant_alone: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !(inv_valid || wb_valid));

endmodule

// File: tb/coh_dir_ctrl_test.sv
// Bench: behavioural directory model compared with the design on every clock.
module coh_dir_ctrl_test;

    localparam int NC  = 4;
    localparam int NL  = 16;
    localparam int IDW = $clog2(NC);
    localparam int LW  = $clog2(NL);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0, req_rwitm = 1'b0;
    logic [IDW-1:0]  req_id = '0;
    logic [LW-1:0]   req_line = '0;
    logic [NC-1:0]   inv_ack = '0;
    logic            wb_done = 1'b0;
    logic            req_ready, inv_valid, wb_valid, grant_valid, grant_excl;
    logic [NC-1:0]   inv_mask;
    logic [IDW-1:0]  wb_owner, grant_id;
    logic [LW-1:0]   msg_line, grant_line;

    int tests = 0, fails = 0, cycles = 0;
    string cur_req = "R1";

    coh_dir_ctrl #(.N_CACHE(NC), .LINES(NL)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_rwitm(req_rwitm), .req_id(req_id), .req_line(req_line),
        .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_ack(inv_ack),
        .wb_valid(wb_valid), .wb_owner(wb_owner), .wb_done(wb_done),
        .msg_line(msg_line), .grant_valid(grant_valid), .grant_id(grant_id),
        .grant_line(grant_line), .grant_excl(grant_excl)
    );

    always #2 clk = ~clk;

    // ---------------- reference model ----------------
    bit [NC-1:0] m_pres [NL];
    bit          m_dirty[NL];
    int  m_phase = 0;           // 0 idle, 1 write-back wait, 2 ack wait
    int  m_id, m_line;
    bit  m_excl;
    bit [NC-1:0] m_pend;
    bit  e_ready = 1, e_grant, e_inv, e_wb, e_excl;
    int  e_gid, e_gline, e_mline, e_owner;
    bit [NC-1:0] e_mask;

    function automatic int holder(bit [NC-1:0] v);
        for (int i = 0; i < NC; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic give(int id, int line, bit x);
        e_grant = 1; e_gid = id; e_gline = line; e_excl = x;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NL; i++) begin m_pres[i] = '0; m_dirty[i] = 0; end
            m_phase = 0; m_pend = '0;
            e_grant = 0; e_inv = 0; e_wb = 0;
        end else begin
            bit [NC-1:0] me;
            e_grant = 0; e_inv = 0; e_wb = 0;
            if (m_phase == 0 && req_valid) begin
                m_id = int'(req_id); m_line = int'(req_line); m_excl = req_rwitm;
                me = NC'(1) << m_id;
                if (m_dirty[m_line] && (m_pres[m_line] & me) != 0) give(m_id, m_line, m_excl);
                else if (m_dirty[m_line]) begin
                    e_wb = 1; e_owner = holder(m_pres[m_line]); e_mline = m_line; m_phase = 1;
                end else if (!m_excl) begin
                    m_pres[m_line] |= me; give(m_id, m_line, 0);
                end else if ((m_pres[m_line] & ~me) != 0) begin
                    e_inv = 1; e_mask = m_pres[m_line] & ~me; m_pend = e_mask;
                    e_mline = m_line; m_phase = 2;
                end else begin
                    m_pres[m_line] = me; m_dirty[m_line] = 1; give(m_id, m_line, 1);
                end
            end else if (m_phase == 1 && wb_done) begin
                me = NC'(1) << m_id;
                m_dirty[m_line] = 0;
                if (!m_excl) begin
                    m_pres[m_line] |= me; give(m_id, m_line, 0); m_phase = 0;
                end else begin
                    e_inv = 1; e_mask = m_pres[m_line] & ~me; m_pend = e_mask;
                    e_mline = m_line; m_phase = 2;
                end
            end else if (m_phase == 2) begin
                me = NC'(1) << m_id;
                m_pend &= ~inv_ack;
                if (m_pend == 0) begin
                    m_pres[m_line] = me; m_dirty[m_line] = 1; give(m_id, m_line, 1); m_phase = 0;
                end
            end
            e_ready = (m_phase == 0);
        end
    end

    // ---------------- comparison ----------------
    task automatic chk(string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("req_ready (R9)", int'(req_ready), int'(e_ready));
            chk("grant_valid", int'(grant_valid), int'(e_grant));
            chk("inv_valid", int'(inv_valid), int'(e_inv));
            chk("wb_valid", int'(wb_valid), int'(e_wb));
            if (grant_valid && e_grant) begin
                chk("grant_id (R10)", int'(grant_id), e_gid);
                chk("grant_line (R10)", int'(grant_line), e_gline);
                chk("grant_excl (R10)", int'(grant_excl), int'(e_excl));
            end
            if (inv_valid && e_inv) begin
                chk("inv_mask (R3)", int'(inv_mask), int'(e_mask));
                chk("msg_line (R3)", int'(msg_line), e_mline);
            end
            if (wb_valid && e_wb) begin
                chk("wb_owner (R6)", int'(wb_owner), e_owner);
                chk("msg_line (R6)", int'(msg_line), e_mline);
            end
        end
    end

    // ---------------- cache responders ----------------
    int wb_delay = 2, wb_wait = 0, ack_gap = 1, gap = 0;
    bit [NC-1:0] tb_pend = '0, tb_mask = '0;

    always @(negedge clk) begin
        wb_done = 1'b0;
        inv_ack = '0;
        if (wb_valid) wb_wait = wb_delay;
        else if (wb_wait > 0) begin
            wb_wait--;
            if (wb_wait == 0) wb_done = 1'b1;
        end
        if (inv_valid) begin
            tb_pend = inv_mask; tb_mask = inv_mask; gap = ack_gap;
        end else if (tb_pend != 0) begin
            if (gap > 0) gap--;
            else begin
                bit [NC-1:0] low;
                low = tb_pend & (~tb_pend + 1'b1);
                inv_ack = low | ~tb_mask;   // stray acks from uninvolved caches (R4)
                tb_pend &= ~low;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(bit x, int id, int line);
        @(negedge clk);
        req_valid = 1'b1; req_rwitm = x; req_id = IDW'(id); req_line = LW'(line);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin @(posedge clk); cycles++; end
        fails++; tests++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle outputs held in reset and right after
        chk("reset req_ready (R1)", int'(req_ready), 1);
        chk("reset grant (R1)", int'(grant_valid), 0);
        chk("reset inv (R1)", int'(inv_valid), 0);
        chk("reset wb (R1)", int'(wb_valid), 0);
        rst_n = 1'b1;
        settle(2);

        cur_req = "R1";   // empty entry: ownership with no invalidate
        send(1, 0, 9); settle(3);

        cur_req = "R2";   // shared reads accumulate, back to back
        send(0, 0, 1); send(0, 1, 1); send(0, 2, 1); settle(2);

        cur_req = "R3";   // ownership against three sharers, staggered acks
        ack_gap = 2;
        send(1, 3, 1); settle(3);
        cur_req = "R4";   // after acks cache 3 alone dirty: read by 3 needs nothing
        send(0, 3, 1); settle(2);

        cur_req = "R5";
        send(1, 1, 2); settle(2);
        cur_req = "R8";
        send(1, 1, 2); send(0, 1, 2); settle(2);

        cur_req = "R6";   // read of dirty line owned by cache 1
        wb_delay = 4;
        send(0, 2, 2); settle(3);
        cur_req = "R3";   // now 1 and 2 share: ownership by 0 invalidates both
        ack_gap = 0;
        send(1, 0, 2); settle(3);

        cur_req = "R7";
        send(1, 2, 3); settle(2);
        wb_delay = 5; ack_gap = 3;
        fork
            send(1, 3, 3);
            begin
                repeat (2) @(negedge clk);
                cur_req = "R9";   // queued request to another line waits
                send(0, 0, 4);
            end
        join
        settle(3);

        cur_req = "R11";  // line 1 still owned by cache 3, line 4 shared by 0
        wb_delay = 1;
        send(0, 0, 1); send(1, 1, 4); send(1, 2, 5); send(0, 3, 6);
        settle(4);

        cur_req = "R10";
        send(0, 2, 15); send(1, 3, 15); settle(4);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule